// File: doc/BRIEF.md
# Peripheral Protection Privilege Configuration

This block holds the per-port security and privilege settings for a set of peripheral protection controllers (PPCs) and drives, for every protected port, a non-secure level and an access-privilege level. Two 4 KB register windows share one request port. The secure window programs which ports are non-secure and the privilege each port has when it stays secure. The non-secure window programs the privilege each port has once it is non-secure.

The PPCs form three groups: two internal APB controllers (slots 0 and 1), up to four APB expansion controllers (slots 2 onward) and up to four AHB expansion controllers (the slots after those). Each controller has a fixed port count set by a parameter. Within a group the controller index is taken from address bits 3:2, so each group occupies one 16-byte row. The per-port access-privilege output selects between the two privilege masks using the port's non-secure bit.

Requests arrive with `req_valid` and are accepted on every cycle; there is no back-pressure. A read is answered on the next cycle by `rsp_valid` and `rsp_rdata`. A write gives no response. Size codes are 0 for byte, 1 for halfword and 2 for word. Code 3 reads the whole word and is ignored for writes. No access ever signals an error.

Top module: `ppc_priv_cfg`

## Requirements
- R1: For each port bit i of slot s, `ppc_priv_o[s][i]` equals the stored non-secure-privilege bit when the port's non-secure bit is 1, and the stored secure-privilege bit otherwise.
- R2: `ppc_nonsec_o[s]` equals the stored non-secure mask of slot s, from the cycle after the write that set it.
- R3: Every stored mask keeps only bits below its controller's port count. Higher written bits read back as 0 and never reach an output.
- R4: In the secure window, word offsets 0x60–0x6C write and read the non-secure mask of the AHB expansion slots. Offsets 0x70–0x74 do the same for internal slots 0–1, and 0x80–0x8C for the APB expansion slots. The index within a group is address bits 3:2.
- R5: In the secure window, offsets 0xA0–0xAC, 0xB0–0xB4 and 0xC0–0xCC write and read the secure-privilege mask of the same three groups. A read returns the value a write to that offset stored.
- R6: In the non-secure window, offsets 0xA0–0xAC, 0xB0–0xB4 and 0xC0–0xCC write and read the non-secure-privilege mask of the same groups. Non-secure-window accesses at the secure-only offsets 0x60–0x8C read 0 and change nothing.
- R7: A write with size code 0 or 1 changes no stored value and no output.
- R8: A read with size code 0 returns bits [7:0], and code 1 returns bits [15:0], of the addressed word shifted right by 8 × address bits 1:0, zero-extended. A word read ignores address bits 1:0.
- R9: Reset clears every stored mask, so all outputs and all mapped reads are 0.
- R10: Unmapped offsets read 0 and ignore writes. These include 0x50, 0x90, the unused slots of a group row, and any offset with address bits 11:8 nonzero.
- R11: Every read gets `rsp_valid` high exactly one cycle later. In any cycle without such a response, `rsp_valid` is low and `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_nonsec | input | 1 | 0 selects the secure window, 1 the non-secure window |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 12 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 32 | Read data |
| ppc_nonsec_o | output | NUM_PPC×W (10×16) | Per-slot, per-port non-secure level |
| ppc_priv_o | output | NUM_PPC×W (10×16) | Per-slot, per-port access-privilege level |

## Verification
The assertions check four things on every cycle. Each read is answered exactly one cycle later, and the response is quiet otherwise. Narrow writes and non-secure-window writes leave the non-secure outputs frozen. A slot holds all its masks when it is not written, and a write to a slot's non-secure or secure-privilege field lands masked to the port count on the next cycle. Only the bench scenarios show the address map itself. That covers which offset reaches which group and slot, and that a secure-privilege read returns the same group its write updated. They also show the byte and halfword lane selection, the mixed per-port privilege selection, and clearing under a reset applied in mid-run.

// File: rtl/ppc_cfg_pkg.sv
package ppc_cfg_pkg;
  typedef enum logic [1:0] {
    FLD_NONE = 2'd0,
    FLD_NS   = 2'd1,
    FLD_SP   = 2'd2,
    FLD_NSP  = 2'd3
  } fld_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int INT_PPCS = 2;
  localparam int ADDR_W   = 12;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/ppc_cfg_decode.sv
module ppc_cfg_decode
  import ppc_cfg_pkg::*;
#(
  parameter int NUM_APB_EXP = 4,
  parameter int NUM_AHB_EXP = 4,
  parameter int IDX_W       = 4
) (
  input  logic             nonsec_win,
  input  logic [9:0]       word_addr,
  output logic             hit,
  output fld_e             fld,
  output logic [IDX_W-1:0] slot
);
  localparam int APB_BASE = INT_PPCS;
  localparam int AHB_BASE = INT_PPCS + NUM_APB_EXP;

  int idx;
  assign idx = int'(word_addr[1:0]);

  always_comb begin
    fld  = FLD_NONE;
    slot = '0;
    if (word_addr[9:6] == 4'h0) begin
      case (word_addr[5:2])
        4'h6: if (!nonsec_win && idx < NUM_AHB_EXP) begin
          fld = FLD_NS;  slot = IDX_W'(AHB_BASE + idx);
        end
        4'h7: if (!nonsec_win && idx < INT_PPCS) begin
          fld = FLD_NS;  slot = IDX_W'(idx);
        end
        4'h8: if (!nonsec_win && idx < NUM_APB_EXP) begin
          fld = FLD_NS;  slot = IDX_W'(APB_BASE + idx);
        end
        4'hA: if (idx < NUM_AHB_EXP) begin
          fld = nonsec_win ? FLD_NSP : FLD_SP;  slot = IDX_W'(AHB_BASE + idx);
        end
        4'hB: if (idx < INT_PPCS) begin
          fld = nonsec_win ? FLD_NSP : FLD_SP;  slot = IDX_W'(idx);
        end
        4'hC: if (idx < NUM_APB_EXP) begin
          fld = nonsec_win ? FLD_NSP : FLD_SP;  slot = IDX_W'(APB_BASE + idx);
        end
        default: ;
      endcase
    end
  end

  assign hit = (fld != FLD_NONE);
endmodule

// File: rtl/ppc_cfg_slot.sv
module ppc_cfg_slot
  import ppc_cfg_pkg::*;
#(
  parameter int PORTS = 16,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  fld_e         wr_fld,
  input  logic [31:0]  wr_data,
  output logic [W-1:0] ns_q,
  output logic [W-1:0] sp_q,
  output logic [W-1:0] nsp_q,
  output logic [W-1:0] nonsec_o,
  output logic [W-1:0] priv_o
);
  function automatic logic [31:0] port_mask();
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i < PORTS);
    return m;
  endfunction

  localparam logic [31:0] MASK32 = port_mask();

  logic [W-1:0] wr_masked;
  assign wr_masked = W'(wr_data & MASK32);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q  <= '0;
      sp_q  <= '0;
      nsp_q <= '0;
    end else if (wr_en) begin
      case (wr_fld)
        FLD_NS:  ns_q  <= wr_masked;
        FLD_SP:  sp_q  <= wr_masked;
        FLD_NSP: nsp_q <= wr_masked;
        default: ;
      endcase
    end
  end

  assign nonsec_o = ns_q;
  assign priv_o   = (ns_q & nsp_q) | (~ns_q & sp_q);

  assert_ns_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fld == FLD_NS) |=> (32'(nonsec_o) == ($past(wr_data) & MASK32)));

  assert_sp_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fld == FLD_SP) |=> (32'(sp_q) == ($past(wr_data) & MASK32)) && $stable(ns_q));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ns_q) && $stable(sp_q) && $stable(nsp_q));
endmodule

// File: rtl/ppc_priv_cfg.sv
module ppc_priv_cfg
  import ppc_cfg_pkg::*;
#(
  parameter int INT0_PORTS  = 4,
  parameter int INT1_PORTS  = 1,
  parameter int EXP_PORTS   = 16,
  parameter int NUM_APB_EXP = 4,
  parameter int NUM_AHB_EXP = 4,
  localparam int NUM_PPC    = INT_PPCS + NUM_APB_EXP + NUM_AHB_EXP,
  localparam int W          = max3(INT0_PORTS, INT1_PORTS, EXP_PORTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_nonsec,
  input  logic                          req_write,
  input  logic [1:0]                    req_size,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [31:0]                   req_wdata,
  output logic                          rsp_valid,
  output logic [31:0]                   rsp_rdata,
  output logic [NUM_PPC-1:0][W-1:0]     ppc_nonsec_o,
  output logic [NUM_PPC-1:0][W-1:0]     ppc_priv_o
);
  localparam int IDX_W = $clog2(NUM_PPC);

  logic             dec_hit;
  fld_e             dec_fld;
  logic [IDX_W-1:0] dec_slot;

  ppc_cfg_decode #(
    .NUM_APB_EXP(NUM_APB_EXP), .NUM_AHB_EXP(NUM_AHB_EXP), .IDX_W(IDX_W)
  ) u_decode (
    .nonsec_win(req_nonsec), .word_addr(req_addr[ADDR_W-1:2]),
    .hit(dec_hit), .fld(dec_fld), .slot(dec_slot)
  );

  logic wr_ok;
  assign wr_ok = req_valid && req_write && (req_size == SZ_WORD) && dec_hit;

  logic [W-1:0] ns_arr  [NUM_PPC];
  logic [W-1:0] sp_arr  [NUM_PPC];
  logic [W-1:0] nsp_arr [NUM_PPC];

  for (genvar g = 0; g < NUM_PPC; g++) begin : g_slot
    localparam int PP = (g == 0) ? INT0_PORTS : (g == 1) ? INT1_PORTS : EXP_PORTS;
    ppc_cfg_slot #(.PORTS(PP), .W(W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_ok && (dec_slot == IDX_W'(g))),
      .wr_fld(dec_fld), .wr_data(req_wdata),
      .ns_q(ns_arr[g]), .sp_q(sp_arr[g]), .nsp_q(nsp_arr[g]),
      .nonsec_o(ppc_nonsec_o[g]), .priv_o(ppc_priv_o[g])
    );
  end

  logic [W-1:0] rd_word;
  always_comb begin
    case (dec_fld)
      FLD_NS:  rd_word = ns_arr[dec_slot];
      FLD_SP:  rd_word = sp_arr[dec_slot];
      FLD_NSP: rd_word = nsp_arr[dec_slot];
      default: rd_word = '0;
    endcase
  end

  logic [31:0] rd32, rd_shift, rd_lane;
  assign rd32     = 32'(rd_word);
  assign rd_shift = rd32 >> {req_addr[1:0], 3'b000};
  always_comb begin
    case (req_size)
      SZ_BYTE: rd_lane = rd_shift & 32'h0000_00FF;
      SZ_HALF: rd_lane = rd_shift & 32'h0000_FFFF;
      default: rd_lane = rd32;
    endcase
  end

  logic rd_req;
  assign rd_req = req_valid && !req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_lane : '0;
    end
  end

  assert_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid && (rsp_rdata == '0));

  assert_narrow_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size != SZ_WORD) |=>
      $stable(ppc_nonsec_o) && $stable(ppc_priv_o));

  assert_ns_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_nonsec) |=> $stable(ppc_nonsec_o));

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !dec_hit) |=> (rsp_rdata == '0));
endmodule

// File: tb/tb_ppc_priv_cfg.sv
`timescale 1ns/1ps
module tb_ppc_priv_cfg;
  localparam int NP = 10;
  localparam int W  = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_nonsec = 0, req_write = 0;
  logic [1:0]  req_size = 2'd2;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NP-1:0][W-1:0] ppc_nonsec_o, ppc_priv_o;

  always #5 clk = ~clk;

  ppc_priv_cfg dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_nonsec(req_nonsec),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ppc_nonsec_o(ppc_nonsec_o), .ppc_priv_o(ppc_priv_o)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int ns_m[NP], sp_m[NP], nsp_m[NP];
  bit exp_v;
  int exp_d;

  function automatic int ports_of(int s);
    return (s == 0) ? 4 : (s == 1) ? 1 : 16;
  endfunction

  // field: 0 none, 1 ns, 2 sp, 3 nsp
  function automatic void bdec(bit win, int a, output int f, output int s);
    int w, g;
    w = a & 'hFFC;
    g = (w >> 2) & 3;
    f = 0; s = 0;
    if (!win && w >= 'h60 && w <= 'h6C) begin f = 1; s = 6 + g; end
    else if (!win && (w == 'h70 || w == 'h74)) begin f = 1; s = g; end
    else if (!win && w >= 'h80 && w <= 'h8C) begin f = 1; s = 2 + g; end
    else if (w >= 'hA0 && w <= 'hAC) begin f = win ? 3 : 2; s = 6 + g; end
    else if (w == 'hB0 || w == 'hB4) begin f = win ? 3 : 2; s = g; end
    else if (w >= 'hC0 && w <= 'hCC) begin f = win ? 3 : 2; s = 2 + g; end
  endfunction

  always @(posedge clk) begin
    int f, s, word;
    if (!rst_n) begin
      foreach (ns_m[k]) begin ns_m[k] = 0; sp_m[k] = 0; nsp_m[k] = 0; end
      exp_v = 0; exp_d = 0;
    end else begin
      exp_v = req_valid && !req_write;
      exp_d = 0;
      if (req_valid) begin
        bdec(req_nonsec, int'(req_addr), f, s);
        word = (f == 1) ? ns_m[s] : (f == 2) ? sp_m[s] : (f == 3) ? nsp_m[s] : 0;
        if (!req_write) begin
          if (req_size == 0)      exp_d = (word >>> (8 * req_addr[1:0])) & 'hFF;
          else if (req_size == 1) exp_d = (word >>> (8 * req_addr[1:0])) & 'hFFFF;
          else                    exp_d = word;
        end else if (req_size == 2 && f != 0) begin
          int v;
          v = int'(req_wdata) & ((1 << ports_of(s)) - 1);
          if (f == 1) ns_m[s] = v;
          else if (f == 2) sp_m[s] = v;
          else nsp_m[s] = v;
        end
      end
    end
  end

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #3;
    for (int s = 0; s < NP; s++) begin
      int ep;
      ep = (ns_m[s] & nsp_m[s]) | (~ns_m[s] & sp_m[s]);
      chk(ppc_nonsec_o[s] == W'(ns_m[s]), "R2 nonsec output", ppc_nonsec_o[s], ns_m[s]);
      chk(ppc_priv_o[s] == W'(ep), "R1 priv output", ppc_priv_o[s], ep & 'hFFFF);
    end
    chk(rsp_valid == exp_v, "R11 rsp_valid", rsp_valid, exp_v);
    chk(rsp_rdata == 32'(exp_d), "R11 rsp_rdata", rsp_rdata, exp_d);
  end

  task automatic wr(bit win, logic [1:0] sz, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_nonsec = win; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(bit win, logic [1:0] sz, logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_nonsec = win; req_size = sz; req_addr = a;
    @(posedge clk);
    #3;
    chk(rsp_valid && rsp_rdata == exp, tag, rsp_rdata, exp);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic run();
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, 2, 'h70, 0, "R9 reset ns read");
    chk(ppc_priv_o == '0, "R9 reset outputs", ppc_priv_o[0], 0);
    // masking
    wr(0, 2, 'h70, 32'hFFFF_FFFF);
    rd(0, 2, 'h70, 32'hF, "R3 mask slot0");
    wr(0, 2, 'h74, 32'hFF);
    rd(0, 2, 'h74, 32'h1, "R3 mask slot1");
    // ns groups
    wr(0, 2, 'h84, 32'h1234_A5A5);
    rd(0, 2, 'h84, 32'hA5A5, "R4 apb exp ns");
    wr(0, 2, 'h6C, 32'h0000_00F0);
    rd(0, 2, 'h6C, 32'hF0, "R4 ahb exp ns");
    chk(ppc_nonsec_o[9] == 16'h00F0, "R4 slot9 nonsec", ppc_nonsec_o[9], 'hF0);
    // privilege masks and mixed selection
    wr(0, 2, 'hC4, 32'hFFFF);
    wr(1, 2, 'hC4, 32'h00FF);
    rd(0, 2, 'hC4, 32'hFFFF, "R5 sp readback");
    rd(1, 2, 'hC4, 32'h00FF, "R6 nsp readback");
    chk(ppc_priv_o[3] == 16'h5AFF, "R1 mixed select", ppc_priv_o[3], 'h5AFF);
    wr(0, 2, 'hA0, 32'h3C);
    rd(0, 2, 'hA0, 32'h3C, "R5 ahb sp");
    rd(1, 2, 'hA0, 32'h0, "R6 ahb nsp separate");
    // non-secure window cannot reach ns masks
    wr(1, 2, 'h70, 32'h0);
    rd(0, 2, 'h70, 32'hF, "R6 ns window write ignored");
    rd(1, 2, 'h70, 32'h0, "R6 ns window read zero");
    // narrow writes
    wr(0, 1, 'h84, 32'h0);
    wr(0, 0, 'h84, 32'h0);
    rd(0, 2, 'h84, 32'hA5A5, "R7 narrow write ignored");
    chk(ppc_nonsec_o[3] == 16'hA5A5, "R7 output unchanged", ppc_nonsec_o[3], 'hA5A5);
    // narrow reads
    wr(0, 2, 'h88, 32'hBEEF);
    rd(0, 0, 'h88, 32'hEF, "R8 byte lane0");
    rd(0, 0, 'h89, 32'hBE, "R8 byte lane1");
    rd(0, 1, 'h89, 32'hBE, "R8 half shifted");
    rd(0, 1, 'h8A, 32'h0, "R8 upper half");
    rd(0, 2, 'h8B, 32'hBEEF, "R8 word ignores low bits");
    // unmapped
    wr(0, 2, 'h50, 32'hFFFF);
    rd(0, 2, 'h50, 32'h0, "R10 offset 0x50");
    rd(0, 2, 'h90, 32'h0, "R10 offset 0x90");
    wr(0, 2, 'h78, 32'hFFFF);
    rd(0, 2, 'h78, 32'h0, "R10 unused row slot");
    rd(1, 2, 'h90, 32'h0, "R10 ns window 0x90");
    wr(0, 2, 'h1A0, 32'hFFFF);
    rd(0, 2, 'h1A0, 32'h0, "R10 high address");
    rd(0, 2, 'hA0, 32'h3C, "R10 no alias");
    // random traffic against the model
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom;
      if (r[0]) wr(r[1], 2'(r[3:2] % 3), 12'('h50 + 4 * (r[10:6]) + r[12:11]), $urandom);
      else      rd(r[1], 2'(r[3:2] % 3), 12'('h50 + 4 * (r[10:6]) + r[12:11]),
                   32'(exp_rd_peek(r[1], 2'(r[3:2] % 3), 'h50 + 4 * (r[10:6]) + r[12:11])),
                   "R4 random read");
    end
    // reset in mid-run
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    rd(0, 2, 'h84, 32'h0, "R9 mid-run reset ns");
    rd(1, 2, 'hC4, 32'h0, "R9 mid-run reset nsp");
    repeat (2) @(negedge clk);
  endtask

  function automatic int exp_rd_peek(bit win, logic [1:0] sz, int a);
    int f, s, word;
    bdec(win, a, f, s);
    word = (f == 1) ? ns_m[s] : (f == 2) ? sp_m[s] : (f == 3) ? nsp_m[s] : 0;
    if (sz == 0) return (word >>> (8 * (a & 3))) & 'hFF;
    if (sz == 1) return (word >>> (8 * (a & 3))) & 'hFFFF;
    return word;
  endfunction

  initial begin
    fork
      run();
      begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule